// File: doc/BRIEF.md
# Programmable watchdog reset supervisor

This block watches a host processor and pulls its reset line low when the host stops servicing it. A 2-bit period select chooses one of three timeout lengths, or turns the watchdog off. All timeouts are counted in ticks of a prescaled enable. The host restarts the count by sending a kick strobe. The kick strobe is meant to be the falling edge of a serial chip select.

The period select is not used the moment it changes. It is copied into the active setting in only two cases: on the cycle a read or write command completes, which is marked by a command-complete strobe, and on the last cycle of the power-on hold.

Reset is requested in three situations:
- during the power-on hold;
- for a fixed pulse after a timeout;
- whenever an external supply-low flag is high.

The output is an open-drain style pull-low enable: 1 pulls the line low and 0 releases it. All pins are plain control and status lines. There is no streaming data path, so no valid/ready handshake or back-pressure applies.

Top module: `wdt_supervisor`

## Requirements
- R1: With active select 00 the watchdog expires on the T_LONG-th tick since the last restart, with 01 on the T_MID-th tick, and with 10 on the T_SHORT-th tick. A tick is a clock cycle with `tick_en` high. The reset request begins on the cycle after the expiring tick's edge.
- R2: Active select 11 disables the watchdog and holds its count at zero. The active select is 11 after `rst_n` is asserted.
- R3: `wd_sel` is copied into the active select only on a clock edge where `cmd_done` is high, or on the edge that ends the power-on hold. Changes to `wd_sel` at any other time have no effect on timing.
- R4: While `supply_low` is high, `rst_pull_low` is 1 in the same cycle. `supply_low` does not disturb the watchdog count.
- R5: `rst_pull_low` is 1 while `rst_n` is low. It stays 1 for POR_CYCLES clock cycles after `rst_n` is released, and no ticks are counted during that time.
- R6: A cycle with `kick` high clears the count to zero. A tick in the same cycle is not counted.
- R7: A timeout holds `rst_pull_low` at 1 for exactly PULSE_LEN cycles. Ticks in those cycles are ignored, and counting then restarts from zero.
- R8: `rst_pull_low` is a pull-low enable: 1 means drive the reset line low and 0 means release it. It is 0 only when none of R4, R5 or R7 requests reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| tick_en | input | 1 | Prescaled count enable |
| wd_sel | input | 2 | Requested period select (00 long, 01 mid, 10 short, 11 off) |
| cmd_done | input | 1 | Command-complete strobe; latches `wd_sel` |
| kick | input | 1 | Restart strobe |
| supply_low | input | 1 | Undervoltage flag |
| rst_pull_low | output | 1 | Reset pull-low enable |

## Verification
The bench builds the block with T_LONG=20, T_MID=12, T_SHORT=6, POR_CYCLES=5 and PULSE_LEN=4. With these values every period runs out within a few dozen cycles. This makes it possible to reach repeated timeouts, a select change that is ignored and then adopted, kicks just before expiry, and ticks that arrive during the reset pulse. It also covers both a dense tick pattern and a sparse one, comparing the output on every clock against a behavioural model.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    SEL_LONG  = 2'b00,
    SEL_MID   = 2'b01,
    SEL_SHORT = 2'b10,
    SEL_OFF   = 2'b11
  } wdt_sel_e;
endpackage

// File: rtl/wdt_por_timer.sv
module wdt_por_timer #(
  parameter int POR_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  output logic por_busy,
  output logic por_last
);
  localparam int PW = $clog2(POR_CYCLES + 1);
  logic [PW-1:0] por_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    por_cnt <= '0;
    else if (por_cnt != PW'(POR_CYCLES)) por_cnt <= por_cnt + 1'b1;
  end

  assign por_busy = (por_cnt != PW'(POR_CYCLES));
  assign por_last = (por_cnt == PW'(POR_CYCLES - 1));

  assert_por_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(por_busy) |-> $past(por_last));
  assert_por_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !por_busy |=> !por_busy);
endmodule

// File: rtl/wdt_sel_latch.sv
module wdt_sel_latch
  import wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] wd_sel,
  input  logic       cmd_done,
  input  logic       por_last,
  output wdt_sel_e   active_sel
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   active_sel <= SEL_OFF;
    else if (cmd_done || por_last) active_sel <= wdt_sel_e'(wd_sel);
  end

  assert_sel_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_done || por_last) |=> $stable(active_sel));
endmodule

// File: rtl/wdt_tick_counter.sv
module wdt_tick_counter
  import wdt_pkg::*;
#(
  parameter int T_LONG  = 1400,
  parameter int T_MID   = 600,
  parameter int T_SHORT = 200
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick_en,
  input  logic     kick,
  input  logic     hold_ext,
  input  wdt_sel_e active_sel,
  output logic     expire
);
  localparam int CW = $clog2(T_LONG + 1);
  logic [CW-1:0] cnt;
  logic [CW-1:0] last_val;
  logic          hold;

  always_comb begin
    case (active_sel)
      SEL_LONG:  last_val = CW'(T_LONG - 1);
      SEL_MID:   last_val = CW'(T_MID - 1);
      SEL_SHORT: last_val = CW'(T_SHORT - 1);
      default:   last_val = '0;
    endcase
  end

  assign hold   = hold_ext || kick || (active_sel == SEL_OFF);
  assign expire = !hold && tick_en && (cnt >= last_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (hold)    cnt <= '0;
    else if (tick_en) cnt <= expire ? '0 : cnt + 1'b1;
  end

  assert_off_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (active_sel == SEL_OFF) |=> (cnt == '0));
  assert_kick_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (cnt == '0));
  assert_hold_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hold_ext |=> (cnt == '0));
endmodule

// File: rtl/wdt_pulse_gen.sv
module wdt_pulse_gen #(
  parameter int PULSE_LEN = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  output logic pulse_busy
);
  localparam int LW = $clog2(PULSE_LEN + 1);
  logic [LW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          left <= '0;
    else if (expire)     left <= LW'(PULSE_LEN);
    else if (left != '0) left <= left - 1'b1;
  end

  assign pulse_busy = (left != '0);

  assert_pulse_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (left == LW'(PULSE_LEN)));
  assert_pulse_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_busy && !expire) |=> (left == $past(left) - 1'b1));
endmodule

// File: rtl/wdt_supervisor.sv
module wdt_supervisor
  import wdt_pkg::*;
#(
  parameter int T_LONG     = 1400,
  parameter int T_MID      = 600,
  parameter int T_SHORT    = 200,
  parameter int POR_CYCLES = 64,
  parameter int PULSE_LEN  = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic [1:0] wd_sel,
  input  logic       cmd_done,
  input  logic       kick,
  input  logic       supply_low,
  output logic       rst_pull_low
);
  logic     por_busy, por_last, expire, pulse_busy;
  wdt_sel_e active_sel;

  wdt_por_timer #(.POR_CYCLES(POR_CYCLES)) u_por (
    .clk(clk), .rst_n(rst_n), .por_busy(por_busy), .por_last(por_last));

  wdt_sel_latch u_sel (
    .clk(clk), .rst_n(rst_n), .wd_sel(wd_sel), .cmd_done(cmd_done),
    .por_last(por_last), .active_sel(active_sel));

  wdt_tick_counter #(.T_LONG(T_LONG), .T_MID(T_MID), .T_SHORT(T_SHORT)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .kick(kick),
    .hold_ext(por_busy || pulse_busy), .active_sel(active_sel), .expire(expire));

  wdt_pulse_gen #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst_n(rst_n), .expire(expire), .pulse_busy(pulse_busy));

  assign rst_pull_low = por_busy || pulse_busy || supply_low;

  assert_no_expire_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (active_sel == SEL_OFF) |-> !expire);
  assert_no_expire_por_R5: assert property (@(posedge clk) disable iff (!rst_n)
    por_busy |-> !expire);
endmodule

// File: tb/tb_wdt_supervisor.sv
module tb_wdt_supervisor;
  localparam int TL = 20, TM = 12, TS = 6, PORC = 5, PL = 4;

  logic clk = 0, rst_n = 0, tick_en = 0, cmd_done = 0, kick = 0, supply_low = 0;
  logic [1:0] wd_sel = 2'b00;
  logic rst_pull_low;
  int checks = 0, errors = 0, cycles = 0;
  string cur_req = "R5";

  wdt_supervisor #(.T_LONG(TL), .T_MID(TM), .T_SHORT(TS),
                   .POR_CYCLES(PORC), .PULSE_LEN(PL)) dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wd_sel(wd_sel),
    .cmd_done(cmd_done), .kick(kick), .supply_low(supply_low),
    .rst_pull_low(rst_pull_low));

  always #10 clk = ~clk;

  // behavioural reference
  int m_por, m_act, m_cnt, m_pulse;
  function automatic int lim(int a);
    return (a == 0) ? TL : (a == 1) ? TM : TS;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_por = 0; m_act = 3; m_cnt = 0; m_pulse = 0;
    end else begin
      bit hold, exp_now;
      hold = (m_por < PORC) || (m_pulse > 0) || (m_act == 3) || kick;
      exp_now = !hold && tick_en && (m_cnt >= lim(m_act) - 1);
      if (hold) m_cnt = 0;
      else if (tick_en) m_cnt = exp_now ? 0 : m_cnt + 1;
      if (exp_now) m_pulse = PL;
      else if (m_pulse > 0) m_pulse--;
      if (cmd_done || m_por == PORC - 1) m_act = int'(wd_sel);
      if (m_por < PORC) m_por++;
    end
  end

  always @(negedge clk) begin
    bit expv;
    cycles++;
    expv = (m_por < PORC) || (m_pulse > 0) || supply_low;
    checks++;
    if (rst_pull_low !== expv) begin
      errors++;
      $display("FAIL %s cycle %0d: rst_pull_low=%b expected %b", cur_req, cycles, rst_pull_low, expv);
    end
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic run(input int n, input int period);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      tick_en = (i % period == 0);
      cmd_done = 0; kick = 0;
    end
  endtask

  task automatic strobe_cmd();
    @(posedge clk); #2; cmd_done = 1; tick_en = 1; kick = 0;
  endtask

  task automatic strobe_kick();
    @(posedge clk); #2; kick = 1; tick_en = 1; cmd_done = 0;
  endtask

  initial begin
    // R5: reset state and power-on hold; R3: sel latched at end of hold
    wd_sel = 2'b00;
    repeat (3) @(negedge clk);
    checks++;
    if (rst_pull_low !== 1'b1) begin
      errors++; $display("FAIL R5 in reset: got %b expected 1", rst_pull_low);
    end
    #3 rst_n = 1;
    cur_req = "R5"; run(PORC + 2, 1);
    // R1: long period with dense ticks, and R7 pulse and restart
    cur_req = "R1"; run(TL * 3, 1);
    cur_req = "R7"; run(TL + PL, 1);
    // R3: change without command is ignored
    wd_sel = 2'b10; cur_req = "R3"; run(TL * 2, 1);
    // R3/R1: command adopts short period
    strobe_cmd(); cur_req = "R1"; run(TS * 5, 1);
    // R6: kicks keep it quiet
    cur_req = "R6";
    for (int k = 0; k < 6; k++) begin run(TS - 1, 1); strobe_kick(); end
    run(TS * 2, 1);
    // mid period with sparse ticks
    wd_sel = 2'b01; strobe_cmd(); cur_req = "R1"; run(TM * 3 * 3, 3);
    // R4: supply low with counting continuing
    cur_req = "R4";
    @(posedge clk); #2; supply_low = 1; run(7, 1);
    @(posedge clk); #2; supply_low = 0; run(TM * 2, 1);
    @(posedge clk); #2; supply_low = 1; run(2, 2);
    @(posedge clk); #2; supply_low = 0;
    // R2: disable
    wd_sel = 2'b11; strobe_cmd(); cur_req = "R2"; run(TL * 4, 1);
    // R8: released output with no request
    checks++;
    @(negedge clk);
    if (rst_pull_low !== 1'b0) begin
      errors++; $display("FAIL R8 idle: got %b expected 0", rst_pull_low);
    end
    // R2: reset default is off; sel 11 presented at power-up
    cur_req = "R2";
    @(posedge clk); #2; rst_n = 0; wd_sel = 2'b11;
    run(3, 1); #1 rst_n = 1;
    run(PORC + TL * 3, 1);
    // R3: power-up picks short setting
    cur_req = "R3";
    @(posedge clk); #2; rst_n = 0; wd_sel = 2'b10;
    run(2, 1); #1 rst_n = 1;
    run(PORC + TS * 4, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule